// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It fetches the word addressed by the program counter, decodes it, reads two general registers, runs the arithmetic unit, optionally reads or writes a data word, and writes the result back, all in one cycle. It supports a small instruction subset:

- register-register add, subtract, and, or, xor and nor;
- add-immediate;
- word load and word store;
- branch-if-equal and branch-if-not-equal;
- an unconditional jump.

Each control signal is a separate combinational equation of the opcode field. Branch redirection is further gated by a condition that depends on the data. The program counter sees no delay slot.

The core holds a 32-entry register file, a word-addressed instruction array and a word-addressed data array. A loader writes the instruction array through a dedicated write port, normally while reset is held. Two combinational debug ports show any register and any data word, so results can be observed without disturbing execution. The current program counter is also an output.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset is held, the program counter reads 0 and every register reads 0. Writes to the data array are suppressed during reset.
- R2: Opcode 0x00 is register-register. The funct field selects the operation:
  - 0x20 add
  - 0x22 subtract (rs minus rt)
  - 0x24 and
  - 0x25 or
  - 0x26 xor
  - 0x27 nor

  The operands are the registers in rs (bits 25:21) and rt (bits 20:16). The result is written to the register in rd (bits 15:11).
- R3: Opcode 0x08 writes to register rt the value of register rs plus the 16-bit immediate in bits 15:0, sign-extended.
- R4: The effective address is register rs plus the sign-extended immediate. The data word index is address bits 7:2.
  - Opcode 0x2B stores register rt to that word and writes no register.
  - Opcode 0x23 loads that word into register rt.
- R5: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch goes to PC+4 plus the sign-extended immediate times 4; otherwise the next PC is PC+4. The instruction after a taken branch is not executed.
- R6: Opcode 0x02 sets the PC to {PC[31:28], bits 25:0, 2'b00}. The instruction after it is not executed.
- R7: A write to register 0 is discarded, and register 0 always reads 0.
- R8: An unrecognised opcode, or opcode 0x00 with a funct code outside R2, changes no register and no data word. It only advances the PC by 4.
- R9: A register written by one instruction is visible to the next instruction in the following cycle. Instructions are fetched from word PC bits 7:2 of the instruction array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write enable of the instruction loader |
| load_addr | input | 6 | Instruction word index to write |
| load_data | input | 32 | Instruction word to write |
| dbg_rsel | input | 5 | Register number shown on dbg_rdata |
| dbg_rdata | output | 32 | Current value of the selected register |
| dbg_daddr | input | 6 | Data word index shown on dbg_ddata |
| dbg_ddata | output | 32 | Current value of the selected data word |
| pc | output | 32 | Current program counter |

## Verification
Every architectural effect of an instruction presented at the PC is due exactly one rising edge later. This covers the new PC, the written register and the stored data word.

The bench advances a reference model by one instruction and then waits for the following falling edge. At that edge it compares the PC, the destination register and any stored word against the model. Both debug reads are combinational, so the bench gives each selection a 10 ps settle time and finishes every read well before the next rising edge. Reset-state values are sampled while reset is still held.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    typedef enum logic [5:0] {
        OP_REG  = 6'h00,
        OP_JMP  = 6'h02,
        OP_BEQ  = 6'h04,
        OP_BNE  = 6'h05,
        OP_ADDI = 6'h08,
        OP_LW   = 6'h23,
        OP_SW   = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_XOR = 6'h26,
        FN_NOR = 6'h27
    } funct_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    src_imm;
        logic    wb_from_mem;
        logic    rf_we;
        logic    mem_rd;
        logic    mem_wr;
        logic    branch;
        logic    branch_ne;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    logic is_reg, fn_ok, is_addi, is_lw, is_sw, is_beq, is_bne, is_jmp;
    alu_op_e fn_op;

    always_comb begin
        is_reg  = (opcode == OP_REG);
        is_addi = (opcode == OP_ADDI);
        is_lw   = (opcode == OP_LW);
        is_sw   = (opcode == OP_SW);
        is_beq  = (opcode == OP_BEQ);
        is_bne  = (opcode == OP_BNE);
        is_jmp  = (opcode == OP_JMP);

        fn_ok = 1'b1;
        case (funct)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_XOR:  fn_op = ALU_XOR;
            FN_NOR:  fn_op = ALU_NOR;
            default: begin
                fn_op = ALU_ADD;
                fn_ok = 1'b0;
            end
        endcase

        ctrl.dst_is_rd   = is_reg;
        ctrl.src_imm     = !is_reg && !is_beq && !is_bne;
        ctrl.wb_from_mem = is_lw;
        ctrl.rf_we       = (is_reg && fn_ok) || is_addi || is_lw;
        ctrl.mem_rd      = is_lw;
        ctrl.mem_wr      = is_sw;
        ctrl.branch      = is_beq || is_bne;
        ctrl.branch_ne   = is_bne;
        ctrl.jump        = is_jmp;

        if (is_reg)
            ctrl.alu_op = fn_op;
        else if (is_beq || is_bne)
            ctrl.alu_op = ALU_SUB;
        else
            ctrl.alu_op = ALU_ADD;
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter  int NREGS = 32,
    parameter  int W     = 32,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);
    logic [W-1:0] regs_q [NREGS];
    logic [W-1:0] regs_d [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we && waddr != '0)
            regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++)
                regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
        rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
        rd3 = (ra3 == '0) ? '0 : regs_q[ra3];
    end

    // A write aimed at register 0 leaves it zero.
    assert_r0_stays_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0) |=> (regs_q[0] == '0));

    // A write is visible on the next cycle.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (regs_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter  int IMEM_DEPTH = 64,
    parameter  int DMEM_DEPTH = 64,
    localparam int IAW = $clog2(IMEM_DEPTH),
    localparam int DAW = $clog2(DMEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [IAW-1:0]    load_addr,
    input  logic [XLEN-1:0]   load_data,
    input  logic [REG_AW-1:0] dbg_rsel,
    output logic [XLEN-1:0]   dbg_rdata,
    input  logic [DAW-1:0]    dbg_daddr,
    output logic [XLEN-1:0]   dbg_ddata,
    output logic [XLEN-1:0]   pc
);
    logic [XLEN-1:0] pc_q, pc_d;
    logic [XLEN-1:0] imem_q [IMEM_DEPTH];
    logic [XLEN-1:0] imem_d [IMEM_DEPTH];
    logic [XLEN-1:0] dmem_q [DMEM_DEPTH];
    logic [XLEN-1:0] dmem_d [DMEM_DEPTH];

    logic [XLEN-1:0]   instr, pc4, imm_sext, br_target, j_target;
    logic [XLEN-1:0]   rs_val, rt_val, alu_b, alu_y, ld_val, wb_val;
    logic [REG_AW-1:0] wsel;
    logic [DAW-1:0]    didx;
    logic              alu_zero, take, rf_we, dmem_we;
    logic              unused_bits;
    ctrl_t             ctrl;

    assign instr       = imem_q[pc_q[IAW+1:2]];
    assign unused_bits = ^{instr[10:6], alu_y[XLEN-1:DAW+2], alu_y[1:0]};

    sc_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.NREGS(1 << REG_AW), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (wsel),
        .wdata (wb_val),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .ra3   (dbg_rsel),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .rd3   (dbg_rdata)
    );

    sc_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        imm_sext  = {{16{instr[15]}}, instr[15:0]};
        alu_b     = ctrl.src_imm ? imm_sext : rt_val;
        wsel      = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
        didx      = alu_y[DAW+1:2];
        ld_val    = dmem_q[didx];
        wb_val    = ctrl.wb_from_mem ? ld_val : alu_y;
        rf_we     = ctrl.rf_we && !rst;
        dmem_we   = ctrl.mem_wr && !rst;

        pc4       = pc_q + 32'd4;
        br_target = pc4 + {imm_sext[XLEN-3:0], 2'b00};
        j_target  = {pc_q[31:28], instr[25:0], 2'b00};
        take      = ctrl.branch && (alu_zero != ctrl.branch_ne);

        if (ctrl.jump)
            pc_d = j_target;
        else if (take)
            pc_d = br_target;
        else
            pc_d = pc4;

        imem_d = imem_q;
        if (load_en)
            imem_d[load_addr] = load_data;

        dmem_d = dmem_q;
        if (dmem_we)
            dmem_d[didx] = rt_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_d;
        imem_q <= imem_d;
        dmem_q <= dmem_d;
    end

    assign pc        = pc_q;
    assign dbg_ddata = dmem_q[dbg_daddr];

    // Non-control instructions step the PC by one word.
    assert_seq_step_R8: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.branch || ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

    // A branch whose condition fails falls through.
    assert_fallthrough_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && (alu_zero == ctrl.branch_ne)) |=> (pc_q == $past(pc_q) + 32'd4));

    // A jump keeps the top four PC bits and lands word aligned.
    assert_jump_region_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc_q[31:28] == $past(pc_q[31:28]) && pc_q[1:0] == 2'b00));

    // A store updates the addressed data word with register rt.
    assert_store_lands_R4: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> (dmem_q[$past(didx)] == $past(rt_val)));

endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
    localparam int ID = 64;
    localparam int DD = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_rsel = '0;
    logic [31:0] dbg_rdata;
    logic [5:0]  dbg_daddr = '0;
    logic [31:0] dbg_ddata;
    logic [31:0] pc;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_reg  [32];
    logic [31:0] m_dmem [DD];
    logic [31:0] m_imem [ID];
    logic [31:0] m_pc;

    always #4 clk = ~clk;

    sc_core #(.IMEM_DEPTH(ID), .DMEM_DEPTH(DD)) uut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_rsel(dbg_rsel), .dbg_rdata(dbg_rdata),
        .dbg_daddr(dbg_daddr), .dbg_ddata(dbg_ddata), .pc(pc)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd,
                                          input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt,
                                          input int rs, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'h02, tgt};
    endfunction

    function automatic string tag_of(input logic [31:0] ins);
        case (ins[31:26])
            6'h00: begin
                case (ins[5:0])
                    6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27: return "R2";
                    default: return "R8";
                endcase
            end
            6'h08: return "R3";
            6'h23, 6'h2B: return "R4";
            6'h04, 6'h05: return "R5";
            6'h02: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Reference model of one instruction, written from the requirements.
    task automatic model_step(output int dest, output int sidx);
        logic [31:0] ins, a, b, imm, pc4, nxt, ea, val;
        int rs, rt, rd;
        ins = m_imem[m_pc[7:2]];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = m_reg[rs]; b = m_reg[rt];
        imm = {{16{ins[15]}}, ins[15:0]};
        pc4 = m_pc + 32'd4; nxt = pc4;
        dest = 0; sidx = -1; val = '0;
        case (ins[31:26])
            6'h00: begin
                dest = rd;
                case (ins[5:0])
                    6'h20: val = a + b;
                    6'h22: val = a - b;
                    6'h24: val = a & b;
                    6'h25: val = a | b;
                    6'h26: val = a ^ b;
                    6'h27: val = ~(a | b);
                    default: dest = 0;
                endcase
            end
            6'h08: begin dest = rt; val = a + imm; end
            6'h23: begin ea = a + imm; dest = rt; val = m_dmem[ea[7:2]]; end
            6'h2B: begin ea = a + imm; m_dmem[ea[7:2]] = b; sidx = int'(ea[7:2]); end
            6'h04: if (a == b) nxt = pc4 + (imm << 2);
            6'h05: if (a != b) nxt = pc4 + (imm << 2);
            6'h02: nxt = {m_pc[31:28], ins[25:0], 2'b00};
            default: ;
        endcase
        if (dest != 0) m_reg[dest] = val;
        m_pc = nxt;
    endtask

    task automatic read_reg(input int r, output logic [31:0] v);
        dbg_rsel = 5'(r); #0.01; v = dbg_rdata;
    endtask

    task automatic read_mem(input int i, output logic [31:0] v);
        dbg_daddr = 6'(i); #0.01; v = dbg_ddata;
    endtask

    // Hold reset, load the program, check the reset state, then release.
    task automatic start_program();
        logic [31:0] v;
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < ID; i++) begin
            load_en = 1'b1; load_addr = 6'(i); load_data = m_imem[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        for (int r = 0; r < 32; r++) m_reg[r] = '0;
        m_pc = '0;
        check("R1", "reset pc", pc, 32'd0);
        for (int r = 0; r < 32; r += 7) begin
            read_reg(r, v);
            check("R1", "reset reg", v, 32'd0);
        end
        rst = 1'b0;
    endtask

    task automatic run_cycles(input int n);
        int dest, sidx;
        string tg;
        logic [31:0] v;
        for (int k = 0; k < n; k++) begin
            tg = tag_of(m_imem[m_pc[7:2]]);
            model_step(dest, sidx);
            @(negedge clk);
            check(tg, "next pc", pc, m_pc);
            read_reg(dest, v);
            check((dest == 0) ? "R7" : "R9", "dest reg", v, m_reg[dest]);
            if (sidx >= 0) begin
                read_mem(sidx, v);
                check("R4", "stored word", v, m_dmem[sidx]);
            end
        end
    endtask

    task automatic full_compare(input string req);
        logic [31:0] v;
        for (int r = 0; r < 32; r++) begin
            read_reg(r, v);
            check(req, "final reg", v, m_reg[r]);
        end
        for (int i = 0; i < DD; i++) begin
            read_mem(i, v);
            check(req, "final word", v, m_dmem[i]);
        end
    endtask

    function automatic logic [31:0] rand_instr();
        int k, a, b, c;
        logic [5:0] fns [7];
        fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27, 6'h21};
        k = int'($urandom % 16);
        a = int'($urandom % 8); b = int'($urandom % 8); c = int'($urandom % 8);
        if (k < 5)       return enc_r(fns[$urandom % 7], a, b, c);
        else if (k < 8)  return enc_i(6'h08, a, b, 16'($urandom));
        else if (k < 10) return enc_i(6'h2B, a, b, 16'($urandom));
        else if (k < 12) return enc_i(6'h23, a, b, 16'($urandom));
        else if (k < 14) return enc_i(($urandom % 2) ? 6'h04 : 6'h05, a, b,
                                      16'(int'($urandom % 17) - 8));
        else if (k < 15) return enc_j(26'($urandom));
        else             return {6'h3F, 26'($urandom)};
    endfunction

    initial begin
        #(8ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int seed_sink;
        seed_sink = int'($urandom(32'd2718));

        // Clear every data word with a store loop (R4, R5 loop branch).
        for (int i = 0; i < ID; i++) m_imem[i] = '0;
        m_imem[0] = enc_i(6'h08, 2, 0, 16'd256);
        m_imem[1] = enc_i(6'h2B, 0, 1, 16'd0);
        m_imem[2] = enc_i(6'h08, 1, 1, 16'd4);
        m_imem[3] = enc_i(6'h05, 2, 1, 16'hFFFD);
        for (int i = 0; i < DD; i++) m_dmem[i] = '0;
        start_program();
        run_cycles(200);
        full_compare("R4");

        // Directed corner cases.
        for (int i = 0; i < ID; i++) m_imem[i] = '0;
        m_imem[0]  = enc_i(6'h08, 1, 0, 16'hFFFD);
        m_imem[1]  = enc_i(6'h08, 2, 1, 16'd10);
        m_imem[2]  = enc_i(6'h08, 0, 0, 16'd5);
        m_imem[3]  = enc_r(6'h22, 3, 2, 1);
        m_imem[4]  = enc_i(6'h2B, 3, 2, 16'd5);
        m_imem[5]  = enc_i(6'h23, 4, 0, 16'd12);
        m_imem[6]  = enc_i(6'h04, 3, 4, 16'd1);
        m_imem[7]  = enc_i(6'h08, 5, 0, 16'd1);
        m_imem[8]  = enc_i(6'h05, 3, 4, 16'd5);
        m_imem[9]  = enc_j(26'd11);
        m_imem[10] = enc_i(6'h08, 6, 0, 16'd1);
        m_imem[11] = {6'h3F, 5'd2, 5'd7, 16'h1234};
        m_imem[12] = enc_r(6'h00, 7, 2, 2);
        m_imem[13] = enc_r(6'h27, 8, 0, 0);
        m_imem[14] = enc_j(26'd14);
        start_program();
        run_cycles(30);
        read_reg(1, v); check("R3", "negative imm r1", v, 32'hFFFF_FFFD);
        read_reg(2, v); check("R9", "back-to-back r2", v, 32'd7);
        read_reg(0, v); check("R7", "r0 after write", v, 32'd0);
        read_reg(3, v); check("R2", "sub r3", v, 32'd10);
        read_reg(4, v); check("R4", "load r4", v, 32'd10);
        read_mem(3, v); check("R4", "word 3", v, 32'd10);
        read_reg(5, v); check("R5", "skipped after branch", v, 32'd0);
        read_reg(6, v); check("R6", "skipped after jump", v, 32'd0);
        read_reg(7, v); check("R8", "bad funct no write", v, 32'd0);
        read_reg(8, v); check("R2", "nor r8", v, 32'hFFFF_FFFF);
        check("R6", "self jump pc", pc, 32'd56);

        // Random programs against the model.
        for (int p = 0; p < 10; p++) begin
            for (int i = 0; i < ID; i++) m_imem[i] = rand_instr();
            start_program();
            run_cycles(200);
            full_compare("R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule